// File: doc/BRIEF.md
# Dual PWM Charge-Pump Controller

This block generates the drive signals for two DC-to-DC charge pumps. Each drive is a pulse-width modulated waveform. One period is sixteen slots, and a 4-bit ratio field sets how many of those slots the drive is active. A single 16-bit register holds three ratio fields and is reached through a simple select/write/read port.

Drive 0 has two ratio fields, one used on battery and one used on an external supply, and the power-source inputs choose between them. Drive 1 has a single field. The slot rate comes from a prescaler that divides the master clock by twelve. With an 18.432 MHz clock, a ratio of 8 therefore gives a 96 kHz square wave.

The active sense of each drive comes from the level on a strap input, captured while power-on reset is asserted. The feedback inputs are captured during power-on reset in the same way. A captured high on a feedback input keeps its pump off for good. A new ratio or a change of power source only takes effect at the next period boundary, so a pulse is never cut short or stretched. While no pump is in use, the prescaler is parked.

Top module: `pump_pwm_ctrl`

## Requirements
- R1: Both `rst_n` low and `por_n` low clear the control register. With `sel` high, `rdata` returns the register and zero-extends it from bit 12 upward. With `sel` low, `rdata` is zero.
- R2: A write (`sel` and `wr_en` high at a clock edge) stores only `wdata[11:0]`. Bits 15:12 are discarded and always read as zero.
- R3: A ratio N from 1 to 15 makes the drive active for N×12 clock cycles out of every 192-cycle period (16 slots of 12 cycles each).
- R4: A ratio of 0 holds the drive at its inactive level.
- R5: Drive 0 uses bits 7:4 (supply ratio) when `ext_pwr` is high or `bat_ok` is low. Otherwise it uses bits 3:0 (battery ratio). Drive 1 always uses bits 11:8.
- R6: A new ratio, or a new choice of field for drive 0, is adopted only at a period boundary. The period in progress completes with its old on-time.
- R7: Each `strap` bit is captured on every clock while `por_n` is low and is held afterwards, including across `rst_n`. A captured 0 makes that drive active-high. A captured 1 makes it active-low. The inactive level equals the captured strap value.
- R8: Each `fb` bit is captured while `por_n` is low and is held afterwards. A captured 1 keeps that drive inactive whatever its ratio. Changes on `fb` after power-on reset have no effect.
- R9: While both pumps are idle, the prescaler is parked at zero. A write that makes a ratio nonzero from idle therefore starts the first active slot exactly 12 clock edges after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| por_n | input | 1 | Power-on reset, active low, synchronous; captures strap and feedback |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write strobe, qualified by `sel` |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data |
| ext_pwr | input | 1 | High when running from an external supply |
| bat_ok | input | 1 | High when the battery is usable |
| strap | input | 2 | Drive pin levels seen during power-on reset |
| fb | input | 2 | Feedback inputs; a high level captured during power-on reset disables that pump |
| drv | output | 2 | Pump drive outputs |

## Verification
The bench sweeps every ratio under all three power-source combinations and counts the active cycles per period. A wrong slot comparison or prescaler count would show up as an off-by-one slot (12 cycles) in those counts. A wrong field select would show the other field's duty.

Two tests change the ratio or the power source in the middle of a pulse and measure the pulse, the gap and the next pulse. A design without period-boundary adoption would cut the pulse short. A mixed strap pattern, together with a feedback bit that changes after power-on reset, exposes a polarity that is swapped, not held, or gated by live feedback. The start-up latency from idle exposes a prescaler that is not parked.

// File: rtl/pump_pwm_ctrl.sv
module pump_pwm_ctrl #(
  parameter int PRESCALE = 12,
  parameter int RATIO_W  = 4,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ext_pwr,
  input  logic              bat_ok,
  input  logic [1:0]        strap,
  input  logic [1:0]        fb,
  output logic [1:0]        drv
);
  localparam int CFG_W     = 3 * RATIO_W;
  localparam int PRE_W     = $clog2(PRESCALE);
  localparam int LAST_SLOT = (1 << RATIO_W) - 1;

  logic [CFG_W-1:0]   ctl;
  logic [PRE_W-1:0]   pre;
  logic [1:0]         pol, fb_lat;
  logic [RATIO_W-1:0] nxt [2];
  logic [RATIO_W-1:0] shadow [2];
  logic [RATIO_W-1:0] slot [2];
  logic               on_ac, run, tick;

  always_ff @(posedge clk)
    if (!por_n) begin
      pol    <= strap;
      fb_lat <= fb;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              ctl <= '0;
    else if (!por_n)         ctl <= '0;
    else if (sel && wr_en)   ctl <= wdata[CFG_W-1:0];

  assign rdata  = sel ? DATA_W'(ctl) : '0;
  assign on_ac  = ext_pwr | ~bat_ok;
  assign nxt[0] = on_ac ? ctl[2*RATIO_W-1:RATIO_W] : ctl[RATIO_W-1:0];
  assign nxt[1] = ctl[3*RATIO_W-1:2*RATIO_W];

  assign run  = ((nxt[0] != 0) && !fb_lat[0]) || ((nxt[1] != 0) && !fb_lat[1]) ||
                (shadow[0] != 0) || (shadow[1] != 0);
  assign tick = run && (pre == PRE_W'(PRESCALE - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               pre <= '0;
    else if (!por_n || !run)  pre <= '0;
    else if (tick)            pre <= '0;
    else                      pre <= pre + 1'b1;

  for (genvar g = 0; g < 2; g++) begin : g_pwm
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        shadow[g] <= '0;
        slot[g]   <= '0;
      end else if (!por_n) begin
        shadow[g] <= '0;
        slot[g]   <= '0;
      end else if (tick) begin
        if (shadow[g] == 0 || slot[g] == RATIO_W'(LAST_SLOT)) begin
          shadow[g] <= fb_lat[g] ? '0 : nxt[g];
          slot[g]   <= '0;
        end else begin
          slot[g] <= slot[g] + 1'b1;
        end
      end

    assign drv[g] = ((shadow[g] != 0) && (slot[g] < shadow[g])) ^ pol[g];

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (shadow[g] == 0) |-> (drv[g] == pol[g]));                       // R4
    AST_FB_BLOCK: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      fb_lat[g] |-> (drv[g] == pol[g]));                              // R8
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    pre <= PRE_W'(PRESCALE - 1));                                      // R3
  AST_PARKED_START: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(run) |-> (pre == 0));                                        // R9
  AST_HOLD_PERIOD: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !tick |=> ($stable(shadow[0]) && $stable(shadow[1])));             // R6
  AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    1'b1 |=> ($stable(pol) && $stable(fb_lat)));                       // R7
  AST_WRITE_MASK: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (sel && wr_en) |=> (DATA_W'(ctl) == ($past(wdata) & DATA_W'({CFG_W{1'b1}})))); // R2
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rdata[DATA_W-1:CFG_W] == 0);                                       // R2
endmodule

// File: tb/test_pump_pwm_ctrl.sv
`timescale 1ns/1ps
module test_pump_pwm_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0, sel = 1'b0, wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ext_pwr = 1'b0, bat_ok = 1'b1;
  logic [1:0]  strap = 2'b01, fb = 2'b00, drv, polx = 2'b01;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  pump_pwm_ctrl i_pump_pwm_ctrl (.clk, .rst_n, .por_n, .sel, .wr_en, .wdata, .rdata,
                                 .ext_pwr, .bat_ok, .strap, .fb, .drv);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit act(input int i);
    return drv[i] ^ polx[i];
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); sel = 1'b1; wr_en = 1'b1; wdata = d;
    @(negedge clk); sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic count(input int n, output int c0, output int c1);
    c0 = 0; c1 = 0;
    for (int k = 0; k < n; k++) begin step(); c0 += act(0); c1 += act(1); end
  endtask

  task automatic run_len(input int i, input bit lvl, output int n);
    n = 0;
    while (act(i) == lvl && n < 4000) begin step(); n++; end
  endtask

  task automatic power_on(input logic [1:0] s, input logic [1:0] f);
    @(negedge clk); por_n = 1'b0; strap = s; fb = f; polx = s;
    repeat (4) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    wait (cyc >= 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int c0, c1, x, p, g, e0;
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    power_on(2'b01, 2'b00);
    sel = 1'b1; #1;
    chk("R1 reset readback", rdata, 0);
    sel = 1'b0; #1;
    chk("R7 inactive levels after power-on", drv, 2'b01);

    wr(16'hF5A3);
    sel = 1'b1; #1;
    chk("R2 upper bits dropped", rdata, 16'h05A3);
    sel = 1'b0; #1;
    chk("R1 rdata zero when unselected", rdata, 0);

    for (int src = 0; src < 3; src++) begin
      ext_pwr = (src == 1); bat_ok = (src != 2);
      for (int n = 0; n < 16; n++) begin
        d = {4'hC, 4'(n), 4'(15 - n), 4'(n)};
        wr(d);
        sel = 1'b1; #1;
        chk("R1 readback", rdata, {4'h0, d[11:0]});
        sel = 1'b0;
        repeat (384) @(posedge clk);
        #1;
        count(384, c0, c1);
        e0 = (src == 0) ? n : 15 - n;
        chk((src == 0) ? "R5 battery field R3 duty" : "R5 supply field R3 duty", c0, e0 * 24);
        chk(n == 0 ? "R4 ratio zero drive 1" : "R3 duty drive 1", c1, n * 24);
      end
    end

    ext_pwr = 1'b0; bat_ok = 1'b1;
    wr(16'h0000);
    repeat (400) @(posedge clk);
    wr(16'h0005);
    repeat (11) @(posedge clk);
    #1 chk("R9 no pulse before 12 edges", act(0), 0);
    step();
    chk("R9 first slot after 12 edges", act(0), 1);

    wr(16'h0008);
    repeat (600) @(posedge clk);
    #1;
    run_len(0, 1, x); run_len(0, 0, x);
    repeat (29) step();
    sel = 1'b1; wr_en = 1'b1; wdata = 16'h0001;
    step();
    sel = 1'b0; wr_en = 1'b0;
    run_len(0, 1, p); run_len(0, 0, g); run_len(0, 1, x);
    chk("R6 pulse completes after mid-pulse write", 30 + p, 96);
    chk("R6 old gap kept", g, 96);
    chk("R6 new ratio next period", x, 12);

    wr(16'h00A3);
    repeat (600) @(posedge clk);
    #1;
    run_len(0, 1, x); run_len(0, 0, x);
    repeat (5) step();
    ext_pwr = 1'b1;
    run_len(0, 1, p); run_len(0, 0, g); run_len(0, 1, x);
    chk("R6 source change waits R5", 5 + p, 36);
    chk("R6 source gap", g, 156);
    chk("R5 supply field after boundary", x, 120);

    ext_pwr = 1'b0;
    power_on(2'b10, 2'b01);
    chk("R7 new strap inactive levels", drv, 2'b10);
    fb = 2'b10;
    wr(16'h0FFF);
    repeat (400) @(posedge clk);
    #1;
    count(384, c0, c1);
    chk("R8 fb captured high keeps drive 0 off", c0, 0);
    chk("R8 late fb ignored, drive 1 active-low R7", c1, 360);
    chk("R8 drive 0 held at inactive level", drv[0], 0);

    strap = 2'b01;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    sel = 1'b1; #1;
    chk("R1 system reset clears register", rdata, 0);
    sel = 1'b0;
    repeat (300) @(posedge clk);
    #1 chk("R7 polarity held across system reset", drv, 2'b10);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule